// File: doc/BRIEF.md
# PLL Reprogramming Lock Sequencer

This block sits in a clock controller next to an analog PLL and decides when the processor core may use the PLL output. It holds three registers: a lock-interval register, a PLL setting register with multiplier, pre-divider and post-scaler fields, and a control register whose power-down bit switches the PLL off. Out of reset the core runs straight from the reference oscillator. Each time software writes a new PLL setting, the block drops the core clock enable for the programmed number of reference cycles. After that wait the core is moved onto the PLL output.

The block also computes the PLL output rate as a number from the three fields and a reference-frequency parameter. It reports the rate the core is currently running at, which is zero while the core is stalled. When the PLL is powered back up after a power-down, the same stall is applied again before the PLL output is trusted. The analog loop itself is not modelled; only its settling time is.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset the lock register reads all ones, the setting register reads zero, the power-down flag is 0, lock_busy is 0, core_clk_en is 1 and core_on_pll is 0.
- R2: Until the first setting write, and while the core clock is enabled and not on the PLL, core_freq_hz equals the reference frequency REF_HZ.
- R3: wr_sel selects the register: 0 is the lock register, 1 is the setting register and 2 is the control register. In the setting register the multiplier M sits in bits 19:12, the pre-divider P in bits 9:4 and the post-scaler S in bits 1:0. All other bits of a setting write are dropped, so cfg_value reads them as zero. cfg_value changes only on a setting write.
- R4: pll_freq_hz equals 2*(M+8)*REF_HZ / ((P+2)*2^S), rounded down. With REF_HZ = 12 MHz, M=92, P=1 and S=1 give 400 MHz, and M=42, P=2, S=2 give 75 MHz.
- R5: A setting write holds core_clk_en low for exactly L reference cycles, where L is bits 15:0 of the lock register. Bits 31:16 of the lock register have no effect on the wait. While the clock is held, core_freq_hz reads 0.
- R6: After a setting write with the PLL powered, core_on_pll is 1 from the next cycle on. Once the wait ends, core_freq_hz equals pll_freq_hz.
- R7: A setting write made during an active wait restarts the count from L.
- R8: Bit 5 of the control register powers the PLL down. While it is set, core_on_pll is 0 and core_freq_hz equals REF_HZ.
- R9: A control write that clears bit 5 while it is set starts a new wait of L cycles. A control write that leaves bit 5 clear, or that sets it, starts no wait.
- R10: With L = 0, a setting write causes no stall.
- R11: lock_busy is the inverse of core_clk_en on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 lock, 1 setting, 2 control |
| wr_data | input | 32 | Write data |
| lock_value | output | 32 | Lock register contents |
| cfg_value | output | 32 | Setting register contents, with non-field bits zero |
| pll_off | output | 1 | PLL power-down flag |
| lock_busy | output | 1 | High while a lock wait is counting |
| core_clk_en | output | 1 | Core clock enable |
| core_on_pll | output | 1 | Core is sourced from the PLL (otherwise from the reference) |
| pll_freq_hz | output | 40 | Computed PLL output frequency in Hz |
| core_freq_hz | output | 40 | Frequency the core currently runs at, 0 while stalled |

## Verification
On every cycle, the assertions check the following:
- the busy flag and the clock enable stay complementary;
- a setting write with a nonzero interval raises busy on the next cycle;
- a zero interval leaves the clock running;
- a power-up write raises a new wait;
- the PLL is never selected while powered down;
- the setting register changes only when it is written.

Only the bench's scenarios can show the following:
- the exact stall length, including the restart case where the length is the gap between writes plus the interval;
- that the upper lock bits are ignored;
- the numeric frequency for specific field values;
- that repeated power-down or power-up writes start no wait.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [1:0] {
      SEL_LOCK = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // mask of W ones starting at bit LSB, inside a REG_W wide word
   function automatic logic [63:0] field_mask(input int unsigned w, input int unsigned lsb);
      logic [63:0] m;
      m = (64'd1 << w) - 64'd1;
      return m << lsb;
   endfunction

endpackage

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
   import pll_seq_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned M_W     = 8,
   parameter int unsigned M_LSB   = 12,
   parameter int unsigned P_W     = 6,
   parameter int unsigned P_LSB   = 4,
   parameter int unsigned S_W     = 2,
   parameter int unsigned S_LSB   = 0,
   parameter int unsigned PWR_BIT = 5,
   parameter logic [REG_W-1:0] CFG_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] lock_q,
   output logic [REG_W-1:0] cfg_q,
   output logic [M_W-1:0]   m_fld,
   output logic [P_W-1:0]   p_fld,
   output logic [S_W-1:0]   s_fld,
   output logic             off_q,
   output logic             used_q,
   output logic             start_lock
);

   localparam logic [REG_W-1:0] M_MASK   = REG_W'(field_mask(M_W, M_LSB));
   localparam logic [REG_W-1:0] P_MASK   = REG_W'(field_mask(P_W, P_LSB));
   localparam logic [REG_W-1:0] S_MASK   = REG_W'(field_mask(S_W, S_LSB));
   localparam logic [REG_W-1:0] CFG_MASK = M_MASK | P_MASK | S_MASK;

   if (M_LSB + M_W > REG_W) begin : g_bad_m
      $error("multiplier field exceeds register width");
   end
   if (P_LSB + P_W > M_LSB) begin : g_bad_p
      $error("pre-divider field overlaps multiplier field");
   end
   if (S_LSB + S_W > P_LSB) begin : g_bad_s
      $error("post-scaler field overlaps pre-divider field");
   end
   if (PWR_BIT >= REG_W) begin : g_bad_pwr
      $error("power-down bit outside register");
   end

   reg_sel_e sel;
   logic     wr_lock, wr_cfg, wr_ctrl, power_up;

   assign sel      = reg_sel_e'(wr_sel);
   assign wr_lock  = wr_en && (sel == SEL_LOCK);
   assign wr_cfg   = wr_en && (sel == SEL_CFG);
   assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
   assign power_up = wr_ctrl && off_q && !wr_data[PWR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '1;
         cfg_q  <= CFG_RST & CFG_MASK;
         off_q  <= 1'b0;
         used_q <= 1'b0;
      end else begin
         if (wr_lock) begin
            lock_q <= wr_data;
         end
         if (wr_cfg) begin
            cfg_q  <= wr_data & CFG_MASK;
            used_q <= 1'b1;
         end
         if (wr_ctrl) begin
            off_q <= wr_data[PWR_BIT];
         end
      end
   end

   assign start_lock = wr_cfg || power_up;
   assign m_fld      = cfg_q[M_LSB +: M_W];
   assign p_fld      = cfg_q[P_LSB +: P_W];
   assign s_fld      = cfg_q[S_LSB +: S_W];

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             clk_en
);

   if (CNT_W < 1) begin : g_bad_w
      $error("lock counter needs at least one bit");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             en_q;

   always_comb begin
      if (start) begin
         cnt_d = load_val;
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - CNT_W'(1);
      end else begin
         cnt_d = cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         en_q  <= (cnt_d == '0);
      end
   end

   assign busy   = (cnt_q != '0);
   assign clk_en = en_q;

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc #(
   parameter int unsigned REF_HZ    = 12_000_000,
   parameter int unsigned M_W       = 8,
   parameter int unsigned P_W       = 6,
   parameter int unsigned S_W       = 2,
   parameter int unsigned FREQ_W    = 40,
   parameter bit          FREQ_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [M_W-1:0]    m_fld,
   input  logic [P_W-1:0]    p_fld,
   input  logic [S_W-1:0]    s_fld,
   output logic [FREQ_W-1:0] freq_hz
);

   if (FREQ_W > 64) begin : g_bad_w
      $error("frequency width above 64 bits");
   end

   logic [63:0]       num, den, quo;
   logic [FREQ_W-1:0] quo_t;

   always_comb begin
      num = (64'(m_fld) + 64'd8) * 64'd2 * 64'(REF_HZ);
      den = (64'(p_fld) + 64'd2) << s_fld;
      quo = num / den;
   end

   assign quo_t = quo[FREQ_W-1:0];

   if (FREQ_PIPE) begin : g_reg
      logic [FREQ_W-1:0] freq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            freq_q <= '0;
         end else begin
            freq_q <= quo_t;
         end
      end
      assign freq_hz = freq_q;
   end else begin : g_comb
      logic unused_rst;
      assign unused_rst = clk ^ rst_n;
      assign freq_hz    = quo_t;
   end

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq #(
   parameter int unsigned REF_HZ     = 12_000_000,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned LOCK_USE_W = 16,
   parameter int unsigned M_W        = 8,
   parameter int unsigned M_LSB      = 12,
   parameter int unsigned P_W        = 6,
   parameter int unsigned P_LSB      = 4,
   parameter int unsigned S_W        = 2,
   parameter int unsigned S_LSB      = 0,
   parameter int unsigned PWR_BIT    = 5,
   parameter int unsigned FREQ_W     = 40,
   parameter bit          FREQ_PIPE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  lock_value,
   output logic [REG_W-1:0]  cfg_value,
   output logic              pll_off,
   output logic              lock_busy,
   output logic              core_clk_en,
   output logic              core_on_pll,
   output logic [FREQ_W-1:0] pll_freq_hz,
   output logic [FREQ_W-1:0] core_freq_hz
);

   if (LOCK_USE_W > REG_W) begin : g_bad_lock
      $error("lock counter wider than lock register");
   end

   logic [M_W-1:0] m_fld;
   logic [P_W-1:0] p_fld;
   logic [S_W-1:0] s_fld;
   logic           used_q, start_lock;

   pll_seq_regs #(
      .REG_W(REG_W), .M_W(M_W), .M_LSB(M_LSB), .P_W(P_W), .P_LSB(P_LSB),
      .S_W(S_W), .S_LSB(S_LSB), .PWR_BIT(PWR_BIT), .CFG_RST('0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .lock_q(lock_value), .cfg_q(cfg_value), .m_fld(m_fld), .p_fld(p_fld),
      .s_fld(s_fld), .off_q(pll_off), .used_q(used_q), .start_lock(start_lock)
   );

   pll_lock_timer #(
      .CNT_W(LOCK_USE_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_lock),
      .load_val(lock_value[LOCK_USE_W-1:0]),
      .busy(lock_busy), .clk_en(core_clk_en)
   );

   pll_freq_calc #(
      .REF_HZ(REF_HZ), .M_W(M_W), .P_W(P_W), .S_W(S_W),
      .FREQ_W(FREQ_W), .FREQ_PIPE(FREQ_PIPE)
   ) u_freq (
      .clk(clk), .rst_n(rst_n), .m_fld(m_fld), .p_fld(p_fld), .s_fld(s_fld),
      .freq_hz(pll_freq_hz)
   );

   assign core_on_pll = used_q && !pll_off;

   always_comb begin
      if (!core_clk_en) begin
         core_freq_hz = '0;
      end else if (core_on_pll) begin
         core_freq_hz = pll_freq_hz;
      end else begin
         core_freq_hz = FREQ_W'(REF_HZ);
      end
   end

endmodule

// File: rtl/pll_lock_seq_chk.sv
module pll_lock_seq_chk #(
   parameter int unsigned REF_HZ     = 12_000_000,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned LOCK_USE_W = 16,
   parameter int unsigned PWR_BIT    = 5,
   parameter int unsigned FREQ_W     = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  lock_value,
   input logic [REG_W-1:0]  cfg_value,
   input logic              pll_off,
   input logic              lock_busy,
   input logic              core_clk_en,
   input logic              core_on_pll,
   input logic [FREQ_W-1:0] core_freq_hz
);

   logic cfg_wr, pwr_up, lock_zero;
   assign cfg_wr    = wr_en && (wr_sel == 2'd1);
   assign pwr_up    = wr_en && (wr_sel == 2'd2) && pll_off && !wr_data[PWR_BIT];
   assign lock_zero = (lock_value[LOCK_USE_W-1:0] == '0);

   p_busy_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_busy == !core_clk_en);

   p_stall_on_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !lock_zero) |=> (lock_busy && !core_clk_en));

   p_zero_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && lock_zero && !lock_busy) |=> core_clk_en);

   p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_up && !lock_zero) |=> lock_busy);

   p_sel_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !pll_off) |=> core_on_pll);

   p_off_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pll_off |-> !core_on_pll);

   p_ref_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en && !core_on_pll) |-> (core_freq_hz == FREQ_W'(REF_HZ)));

   p_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_value));

endmodule

bind pll_lock_seq pll_lock_seq_chk #(
   .REF_HZ(REF_HZ), .REG_W(REG_W), .LOCK_USE_W(LOCK_USE_W),
   .PWR_BIT(PWR_BIT), .FREQ_W(FREQ_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .lock_value(lock_value), .cfg_value(cfg_value), .pll_off(pll_off),
   .lock_busy(lock_busy), .core_clk_en(core_clk_en), .core_on_pll(core_on_pll),
   .core_freq_hz(core_freq_hz)
);

// File: tb/pll_lock_seq_tb.sv
module pll_lock_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam longint REF    = 12_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] lock_value, cfg_value;
   logic        pll_off, lock_busy, core_clk_en, core_on_pll;
   logic [39:0] pll_freq_hz, core_freq_hz;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_lock_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .lock_value(lock_value), .cfg_value(cfg_value), .pll_off(pll_off),
      .lock_busy(lock_busy), .core_clk_en(core_clk_en), .core_on_pll(core_on_pll),
      .pll_freq_hz(pll_freq_hz), .core_freq_hz(core_freq_hz)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   typedef struct { string tag; int len; } stall_t;
   stall_t exp_q[$];

   task automatic chk(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint fref(input int m, input int p, input int s);
      return (2 * (longint'(m) + 8) * REF) / ((longint'(p) + 2) << s);
   endfunction

   function automatic logic [31:0] cfg_word(input int m, input int p, input int s);
      return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 32'd0;
   endtask

   task automatic expect_stall(input string tag, input int len);
      stall_t it;
      it.tag = tag; it.len = len;
      exp_q.push_back(it);
   endtask

   // monitor: measures each low stretch of the clock enable
   int run = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!core_clk_en) begin
            run++;
         end else if (run != 0) begin
            if (exp_q.size() == 0) begin
               chk("R9/R10 unexpected stall", run, 0);
            end else begin
               stall_t it;
               it = exp_q.pop_front();
               chk(it.tag, run, it.len);
            end
            run = 0;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R2 core on reference
      chk("R1 lock reset", lock_value, 32'hFFFF_FFFF);
      chk("R1 cfg reset", cfg_value, 0);
      chk("R1 pll_off reset", pll_off, 0);
      chk("R1 busy reset", lock_busy, 0);
      chk("R1 clk_en reset", core_clk_en, 1);
      chk("R1 on_pll reset", core_on_pll, 0);
      chk("R2 core on reference", core_freq_hz, REF);

      // R5 upper lock bits ignored: effective interval 8
      wr(2'd0, 32'h0001_0008);
      chk("R5 lock readback", lock_value, 32'h0001_0008);
      expect_stall("R5 stall 400MHz", 8);
      wr(2'd1, cfg_word(92, 1, 1) | 32'h8000_0004);
      chk("R5 busy during wait", lock_busy, 1);
      chk("R5 core freq zero in wait", core_freq_hz, 0);
      chk("R11 busy vs enable", lock_busy, !core_clk_en);
      chk("R6 on_pll after write", core_on_pll, 1);
      repeat (12) @(negedge clk);
      chk("R3 cfg masked", cfg_value, cfg_word(92, 1, 1));
      chk("R4 400MHz", pll_freq_hz, 400_000_000);
      chk("R6 core on pll", core_freq_hz, 400_000_000);
      chk("R11 idle", lock_busy, !core_clk_en);

      // second setting, 75 MHz
      expect_stall("R5 stall 75MHz", 8);
      wr(2'd1, cfg_word(42, 2, 2));
      repeat (12) @(negedge clk);
      chk("R4 75MHz", pll_freq_hz, fref(42, 2, 2));
      chk("R4 75MHz value", pll_freq_hz, 75_000_000);
      chk("R6 core 75MHz", core_freq_hz, 75_000_000);

      // R7 restart: writes 4 edges apart, interval 20 -> 24
      wr(2'd0, 32'd20);
      expect_stall("R7 restart", 24);
      wr(2'd1, cfg_word(100, 3, 0));
      repeat (3) @(negedge clk);
      wr(2'd1, cfg_word(100, 5, 0));
      repeat (30) @(negedge clk);
      chk("R3 last write kept", cfg_value, cfg_word(100, 5, 0));
      chk("R4 M100 P5 S0", pll_freq_hz, fref(100, 5, 0));

      // R10 zero interval
      wr(2'd0, 32'hABCD_0000);
      wr(2'd1, cfg_word(92, 1, 1));
      chk("R10 no stall busy", lock_busy, 0);
      chk("R10 no stall enable", core_clk_en, 1);
      repeat (3) @(negedge clk);
      chk("R10 core 400MHz", core_freq_hz, 400_000_000);

      // R8 / R9 power-down and power-up
      wr(2'd0, 32'd6);
      wr(2'd2, 32'h0000_0020);
      chk("R8 pll_off set", pll_off, 1);
      chk("R8 not on pll", core_on_pll, 0);
      chk("R8 core on reference", core_freq_hz, REF);
      chk("R9 power-down no stall", lock_busy, 0);
      wr(2'd2, 32'h0000_0020);
      chk("R9 repeated power-down no stall", lock_busy, 0);
      expect_stall("R9 relock", 6);
      wr(2'd2, 32'h0000_0000);
      chk("R9 relock busy", lock_busy, 1);
      repeat (10) @(negedge clk);
      chk("R9 back on pll", core_freq_hz, 400_000_000);
      wr(2'd2, 32'h0000_0000);
      chk("R9 already powered no stall", lock_busy, 0);
      repeat (4) @(negedge clk);
      chk("R5 all stalls seen", exp_q.size(), 0);
      finish_run();
   end

endmodule